// File: doc/BRIEF.md
# Clock Divider Setting Search Engine

This block chooses a clock source and divider settings for a requested output frequency. A clock chain downstream has a power-of-two prescaler (shift 0 to 3) followed by an integer divider (1 to 32). Software or a controller supplies the requested rate and the rates of up to four candidate source clocks, then pulses `start`. The block works out a prescaler shift and divider value for each candidate. It then reports the candidate that gives the highest achievable output rate, together with that rate and the chosen settings.

For each candidate, the required divisor is the candidate rate divided by the requested rate, rounded up. The prescaler first removes exact factors of two from that divisor, which costs no accuracy. If the divisor is still too large for the integer stage, the prescaler grows further and the divisor is halved each time, which does cost accuracy. A candidate that cannot be fitted even at the largest prescaler setting is skipped. All divisions run one after another through a single shared multi-cycle restoring divider. `done` pulses for one cycle when the search ends, and `err` pulses with it when no setting was found.

Top module: `clk_sel_search`

## Requirements
- R1: For each candidate, the divisor d is ceil(parent / request). The initial shift is the number of trailing zero bits of d, capped at 3, and d is shifted right by that shift.
- R2: While d > 32 and the shift is at most 3, the shift grows by one and d is halved (truncating). A candidate whose shift ends above 3 is skipped.
- R3: A candidate's rate is (parent >> shift) / d. When `done` is high and `err` is low, `best_rate`, `best_shift` and `best_div` hold the winner's rate, shift (0..3) and divisor (1..32).
- R4: The first valid candidate is accepted. A later candidate replaces it only if its rate is strictly greater, so on a tie the lower index is kept. `best_idx` gives the winner's index.
- R5: Only candidates 0 to `par_count`-1 are considered. A `par_count` above 4 is treated as 4. Candidate i occupies bits [32*i+31 : 32*i] of `par_rates`.
- R6: A candidate whose rate is zero is skipped.
- R7: When no candidate is valid, `done` and `err` are high together, and `best_idx`, `best_rate`, `best_shift` and `best_div` are all zero.
- R8: A request of zero is rejected: `done` and `err` are high in the cycle after `start` is accepted, and all results are zero.
- R9: `done` is high for exactly one cycle per accepted `start`. `err` is high only while `done` is high.
- R10: A `start` that arrives while a search is in progress is ignored, and the running search completes with its own result.
- R11: A `start` given in the cycle in which `done` is high is accepted. The finished results stay visible in that cycle.
- R12: After reset, `done` and `err` are low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; accepted only when idle |
| req_rate | input | 32 | Requested output rate |
| par_rates | input | 128 | Four candidate rates, candidate i at bits [32*i+31:32*i] |
| par_count | input | 3 | Number of candidates to consider (values above 4 act as 4) |
| done | output | 1 | One-cycle pulse at the end of a search |
| err | output | 1 | Pulses with done when no setting was found |
| best_idx | output | 2 | Index of the chosen candidate |
| best_rate | output | 32 | Achieved output rate of the chosen candidate |
| best_shift | output | 2 | Prescaler shift of the chosen candidate |
| best_div | output | 6 | Integer divisor (1..32) of the chosen candidate |

## Verification
Two events can fall in the same cycle: the end-of-search pulse and the acceptance of the next `start`. The bench provokes this by raising `start`, with a fresh set of rates, in the very cycle it sees `done`. It checks that the finished results are still intact in that cycle. It then checks that the second search runs to its own correct result rather than being lost. A second case raises `start` with a zero request partway through a search, and the bench confirms that no instant rejection appears and that the first search's answer is delivered.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_CEIL,
    ST_RATE,
    ST_END
  } sel_st_e;
endpackage

// File: rtl/clk_sel_div.sv
// Shared restoring divider: one quotient bit per cycle, W cycles per divide.
module clk_sel_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         fin,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(W);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic         busy_q, busy_d;
  logic         fin_q, fin_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0] q_q, q_d, r_q, r_d, b_q, b_d;
  logic [W:0]   trial, diff;
  logic         take;

  always_comb begin
    trial = {r_q, q_q[W-1]};
    diff  = trial - {1'b0, b_q};
    take  = ~diff[W];
    busy_d = busy_q;
    fin_d  = 1'b0;
    cnt_d  = cnt_q;
    q_d    = q_q;
    r_d    = r_q;
    b_d    = b_q;
    if (go && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
      q_d    = a;
      r_d    = '0;
      b_d    = b;
    end else if (busy_q) begin
      r_d   = take ? diff[W-1:0] : trial[W-1:0];
      q_d   = {q_q[W-2:0], take};
      cnt_d = cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      cnt_q  <= '0;
      q_q    <= '0;
      r_q    <= '0;
      b_q    <= '0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_d;
      cnt_q  <= cnt_d;
      q_q    <= q_d;
      r_q    <= r_d;
      b_q    <= b_d;
    end
  end

  assign fin  = fin_q;
  assign quot = q_q;
  assign rem  = r_q;
endmodule

// File: rtl/clk_sel_fit.sv
// Fits a rounded-up divisor into prescaler shift plus integer divider.
module clk_sel_fit #(
  parameter int W   = 32,
  parameter int SHB = 2,
  parameter int DVB = 5
) (
  input  logic [W-1:0]   ceil_div,
  output logic [SHB-1:0] shift,
  output logic [DVB:0]   div,
  output logic           ok
);
  localparam int SMAX = (1 << SHB) - 1;
  localparam logic [SHB:0] SMAX_S = (SHB + 1)'(SMAX);
  localparam logic [SHB:0] ONE_S  = (SHB + 1)'(1);
  localparam logic [W-1:0] DMAX_W = W'(1 << DVB);

  logic [SHB:0] s;
  logic [W-1:0] v;
  logic         stop;

  always_comb begin
    s    = '0;
    stop = 1'b0;
    // exact powers of two first: no precision lost
    for (int k = 0; k < SMAX; k++) begin
      if (!stop && !ceil_div[k]) s = s + ONE_S;
      else                       stop = 1'b1;
    end
    v = ceil_div >> s;
    // then lossy halving until the integer stage can hold it
    for (int k = 0; k <= SMAX; k++) begin
      if (s <= SMAX_S && v > DMAX_W) begin
        s = s + ONE_S;
        v = v >> 1;
      end
    end
    ok    = (s <= SMAX_S);
    shift = s[SHB-1:0];
    div   = v[DVB:0];
  end
endmodule

// File: rtl/clk_sel_search.sv
module clk_sel_search
  import clk_sel_pkg::*;
#(
  parameter int W    = 32,
  parameter int NPAR = 4,
  parameter int SHB  = 2,
  parameter int DVB  = 5,
  localparam int IDXW = $clog2(NPAR),
  localparam int IW   = $clog2(NPAR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W-1:0]      req_rate,
  input  logic [NPAR*W-1:0] par_rates,
  input  logic [IW-1:0]     par_count,
  output logic              done,
  output logic              err,
  output logic [IDXW-1:0]   best_idx,
  output logic [W-1:0]      best_rate,
  output logic [SHB-1:0]    best_shift,
  output logic [DVB:0]      best_div
);
  localparam logic [IW-1:0] NPAR_C = IW'(NPAR);
  localparam logic [IW-1:0] IDX_ONE = IW'(1);

  sel_st_e          st_q, st_d;
  logic [IW-1:0]    idx_q, idx_d, cnt_q, cnt_d;
  logic [W-1:0]     req_q, req_d;
  logic [W-1:0]     par_q [NPAR];
  logic [W-1:0]     par_d [NPAR];
  logic             have_q, have_d;
  logic [IDXW-1:0]  bidx_q, bidx_d;
  logic [W-1:0]     brate_q, brate_d;
  logic [SHB-1:0]   bshift_q, bshift_d, cshift_q, cshift_d;
  logic [DVB:0]     bdiv_q, bdiv_d, cdiv_q, cdiv_d;
  logic             done_q, done_d, err_q, err_d;

  logic             dv_go, dv_fin;
  logic [W-1:0]     dv_a, dv_b, dv_quot, dv_rem;
  logic [W-1:0]     cur_par, ceil_w;
  logic [SHB-1:0]   fit_shift;
  logic [DVB:0]     fit_div;
  logic             fit_ok;
  logic             idle_w;

  assign cur_par = par_q[idx_q[IDXW-1:0]];
  assign ceil_w  = dv_quot + {{(W-1){1'b0}}, (dv_rem != '0)};
  assign idle_w  = (st_q == ST_IDLE);

  clk_sel_div #(.W(W)) div_i (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (dv_go),
    .a    (dv_a),
    .b    (dv_b),
    .fin  (dv_fin),
    .quot (dv_quot),
    .rem  (dv_rem)
  );

  clk_sel_fit #(.W(W), .SHB(SHB), .DVB(DVB)) fit_i (
    .ceil_div(ceil_w),
    .shift   (fit_shift),
    .div     (fit_div),
    .ok      (fit_ok)
  );

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    req_d    = req_q;
    have_d   = have_q;
    bidx_d   = bidx_q;
    brate_d  = brate_q;
    bshift_d = bshift_q;
    bdiv_d   = bdiv_q;
    cshift_d = cshift_q;
    cdiv_d   = cdiv_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    for (int i = 0; i < NPAR; i++) par_d[i] = par_q[i];
    dv_go = 1'b0;
    dv_a  = cur_par;
    dv_b  = req_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          req_d    = req_rate;
          for (int i = 0; i < NPAR; i++) par_d[i] = par_rates[i*W +: W];
          cnt_d    = (par_count > NPAR_C) ? NPAR_C : par_count;
          idx_d    = '0;
          have_d   = 1'b0;
          bidx_d   = '0;
          brate_d  = '0;
          bshift_d = '0;
          bdiv_d   = '0;
          if (req_rate == '0) begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end else begin
            st_d = ST_PICK;
          end
        end
      end
      ST_PICK: begin
        if (idx_q >= cnt_q) begin
          st_d = ST_END;
        end else if (cur_par == '0) begin
          idx_d = idx_q + IDX_ONE;
        end else begin
          dv_go = 1'b1;
          st_d  = ST_CEIL;
        end
      end
      ST_CEIL: begin
        if (dv_fin) begin
          if (fit_ok) begin
            cshift_d = fit_shift;
            cdiv_d   = fit_div;
            dv_go    = 1'b1;
            dv_a     = cur_par >> fit_shift;
            dv_b     = {{(W-DVB-1){1'b0}}, fit_div};
            st_d     = ST_RATE;
          end else begin
            idx_d = idx_q + IDX_ONE;
            st_d  = ST_PICK;
          end
        end
      end
      ST_RATE: begin
        if (dv_fin) begin
          if (!have_q || dv_quot > brate_q) begin
            have_d   = 1'b1;
            bidx_d   = idx_q[IDXW-1:0];
            brate_d  = dv_quot;
            bshift_d = cshift_q;
            bdiv_d   = cdiv_q;
          end
          idx_d = idx_q + IDX_ONE;
          st_d  = ST_PICK;
        end
      end
      ST_END: begin
        done_d = 1'b1;
        err_d  = ~have_q;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      cnt_q    <= '0;
      req_q    <= '0;
      have_q   <= 1'b0;
      bidx_q   <= '0;
      brate_q  <= '0;
      bshift_q <= '0;
      bdiv_q   <= '0;
      cshift_q <= '0;
      cdiv_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      for (int i = 0; i < NPAR; i++) par_q[i] <= '0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      cnt_q    <= cnt_d;
      req_q    <= req_d;
      have_q   <= have_d;
      bidx_q   <= bidx_d;
      brate_q  <= brate_d;
      bshift_q <= bshift_d;
      bdiv_q   <= bdiv_d;
      cshift_q <= cshift_d;
      cdiv_q   <= cdiv_d;
      done_q   <= done_d;
      err_q    <= err_d;
      for (int i = 0; i < NPAR; i++) par_q[i] <= par_d[i];
    end
  end

  assign done       = done_q;
  assign err        = err_q;
  assign best_idx   = bidx_q;
  assign best_rate  = brate_q;
  assign best_shift = bshift_q;
  assign best_div   = bdiv_q;
endmodule

// File: rtl/clk_sel_search_chk.sv
module clk_sel_search_chk #(
  parameter int W    = 32,
  parameter int NPAR = 4,
  parameter int SHB  = 2,
  parameter int DVB  = 5,
  localparam int IDXW = $clog2(NPAR)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            idle,
  input logic [W-1:0]    req_rate,
  input logic            done,
  input logic            err,
  input logic [IDXW-1:0] best_idx,
  input logic [W-1:0]    best_rate,
  input logic [SHB-1:0]  best_shift,
  input logic [DVB:0]    best_div
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R9

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (best_div != '0 && int'(best_div) <= (1 << DVB))); // R3

  AST_ERR_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (best_rate == '0 && best_div == '0 && best_shift == '0 && best_idx == '0)); // R7

  AST_ZERO_REQ_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && req_rate == '0) |=> (done && err)); // R8
endmodule

bind clk_sel_search clk_sel_search_chk #(.W(W), .NPAR(NPAR), .SHB(SHB), .DVB(DVB)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .idle      (idle_w),
  .req_rate  (req_rate),
  .done      (done),
  .err       (err),
  .best_idx  (best_idx),
  .best_rate (best_rate),
  .best_shift(best_shift),
  .best_div  (best_div)
);

// File: tb/clk_sel_search_tb_top.sv
`timescale 1ns/1ps
module clk_sel_search_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  req = '0;
  logic [127:0] pars = '0;
  logic [2:0]   pcnt = '0;
  logic         done, err;
  logic [1:0]   bidx, bshift;
  logic [31:0]  brate;
  logic [5:0]   bdiv;

  int n_chk = 0;
  int n_err = 0;
  longint e_idx, e_rate, e_shift, e_div;
  longint e_err;

  always #2.5 clk = ~clk;

  clk_sel_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_rate(req),
    .par_rates(pars), .par_count(pcnt), .done(done), .err(err),
    .best_idx(bidx), .best_rate(brate), .best_shift(bshift), .best_div(bdiv)
  );

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected result from the requirement text (R1..R7)
  function automatic void model(longint rq, longint p0, longint p1, longint p2,
                                longint p3, int cnt);
    longint p [4];
    longint d, r;
    int s, n;
    bit have;
    p[0] = p0; p[1] = p1; p[2] = p2; p[3] = p3;
    n = (cnt > 4) ? 4 : cnt;
    have = 0;
    e_idx = 0; e_rate = 0; e_shift = 0; e_div = 0;
    for (int i = 0; i < n; i++) begin
      if (p[i] == 0) continue;
      d = (p[i] + rq - 1) / rq;
      s = 0;
      while (s < 3 && (d % 2) == 0) begin d = d / 2; s++; end
      while (d > 32) begin
        s++;
        d = d / 2;
        if (s > 3) break;
      end
      if (s > 3) continue;
      r = (p[i] >> s) / d;
      if (!have || r > e_rate) begin
        have = 1; e_idx = i; e_rate = r; e_shift = s; e_div = d;
      end
    end
    e_err = have ? 0 : 1;
  endfunction

  task automatic setin(longint rq, longint p0, longint p1, longint p2, longint p3, int cnt);
    req  = rq[31:0];
    pars = {p3[31:0], p2[31:0], p1[31:0], p0[31:0]};
    pcnt = cnt[2:0];
  endtask

  task automatic kick(longint rq, longint p0, longint p1, longint p2, longint p3, int cnt);
    setin(rq, p0, p1, p2, p3, cnt);
    model(rq, p0, p1, p2, p3, cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int w = 0;
    while (done !== 1'b1 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    if (done !== 1'b1) begin
      n_chk++; n_err++;
      $display("FAIL %s watchdog actual=0 expected=1", tag);
    end
  endtask

  task automatic cmp(string tag);
    check({tag, " R9 done"}, done, 1);
    check({tag, " err"}, err, e_err);
    check({tag, " R4 idx"}, bidx, e_idx);
    check({tag, " R3 rate"}, brate, e_rate);
    check({tag, " R3 shift"}, bshift, e_shift);
    check({tag, " R3 div"}, bdiv, e_div);
  endtask

  task automatic finish_pulse(string tag);
    @(negedge clk);
    check({tag, " R9 done falls"}, done, 0);
    check({tag, " R9 err falls"}, err, 0);
  endtask

  task automatic t_reset();
    check("R12 done", done, 0);
    check("R12 err", err, 0);
    check("R12 rate", brate, 0);
    check("R12 div", bdiv, 0);
    check("R12 shift", bshift, 0);
    check("R12 idx", bidx, 0);
  endtask

  task automatic t_zero_req();
    kick(0, 24000000, 1, 2, 3, 4);
    check("R8 done next cycle", done, 1);
    check("R8 err", err, 1);
    check("R8 rate", brate, 0);
    check("R8 div", bdiv, 0);
    finish_pulse("R8");
  endtask

  task automatic t_exact();
    kick(1000000, 24000000, 32768, 600000000, 200000000, 4);
    wait_done("R1 exact");
    cmp("R1 exact tie");
    check("R1 shift3", bshift, 3);
    check("R1 div3", bdiv, 3);
    check("R4 tie keeps idx0", bidx, 0);
    finish_pulse("R1");
  endtask

  task automatic t_round();
    kick(1000000, 45000000, 0, 0, 0, 1);
    wait_done("R2 round");
    cmp("R2 round");
    check("R2 shift1", bshift, 1);
    check("R2 div22", bdiv, 22);
    check("R2 rate", brate, 1022727);
    finish_pulse("R2");
  endtask

  task automatic t_none();
    kick(1, 64'hFFFF_FFFF, 64'h8000_0000, 64'hFFFF_FFFF, 64'hC000_0001, 4);
    wait_done("R7 none");
    cmp("R7 none");
    check("R7 err", err, 1);
    check("R7 rate zero", brate, 0);
    finish_pulse("R7");
  endtask

  task automatic t_zero_par();
    kick(1000000, 0, 10000000, 0, 0, 4);
    wait_done("R6 zero parent");
    cmp("R6 zero parent");
    check("R6 idx1", bidx, 1);
    check("R6 rate", brate, 1000000);
    finish_pulse("R6");
  endtask

  task automatic t_greater();
    kick(3000000, 100000000, 12000000, 7000001, 99999999, 4);
    wait_done("R4 greater");
    cmp("R4 greater");
    check("R4 idx1", bidx, 1);
    finish_pulse("R4");
  endtask

  task automatic t_count();
    kick(1000000, 24000000, 32768, 600000000, 45000000, 2);
    wait_done("R5 count2");
    cmp("R5 count2");
    check("R5 idx0", bidx, 0);
    finish_pulse("R5");
    kick(1000000, 24000000, 32768, 600000000, 45000000, 7);
    wait_done("R5 clamp");
    cmp("R5 clamp");
    check("R5 idx3", bidx, 3);
    finish_pulse("R5b");
  endtask

  task automatic t_busy_start();
    kick(1000000, 45000000, 24000000, 0, 0, 2);
    repeat (10) @(negedge clk);
    req = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 no reject mid-run", done, 0);
    wait_done("R10 busy");
    cmp("R10 busy");
    finish_pulse("R10");
  endtask

  task automatic t_b2b();
    kick(1000000, 45000000, 0, 0, 0, 1);
    wait_done("R11 first");
    cmp("R11 first kept in done cycle");
    setin(3000000, 100000000, 12000000, 7000001, 99999999, 4);
    model(3000000, 100000000, 12000000, 7000001, 99999999, 4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 done one cycle", done, 0);
    wait_done("R11 second");
    cmp("R11 second");
    finish_pulse("R11");
  endtask

  initial begin
    #1000000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_req();
    t_exact();
    t_round();
    t_none();
    t_zero_par();
    t_greater();
    t_count();
    t_busy_start();
    t_b2b();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule